// File: doc/BRIEF.md
# Radix-8 Booth Interleaved Modular Multiplier

This block computes z = (x · y) mod p for unsigned operands of a parameterised width W. It never forms the full double-width product and never divides. The multiplier y is consumed from its most significant end, three bits per clock. Each step scales the running result by eight modulo p, then modularly adds or subtracts one multiple of x, chosen by a signed radix-8 Booth digit. The multiples x, 2x mod p, 3x mod p and 4x mod p are formed on the clock edge that accepts a start request and are held until the run ends.

The user holds x, y and p on the inputs and pulses `start` for one cycle while the unit is idle. The accumulator is visible on `z_out` at all times. `done` marks the cycle in which `z_out` first carries the final result. That value then stays on `z_out` until the next accepted start. A run takes a fixed number of cycles, floor(W/3)+1, which is 6 for the default W = 16.

Top module: `mod_mul_r8`

## Requirements
- R1: For 0 ≤ x < p, 0 ≤ y < p and p odd with p > 1, the value on `z_out` when `done` is high equals (x · y) mod p. Examples: x=20, y=28, p=29 gives 9; x=12548, y=12540, p=12553 gives 65.
- R2: `done` rises exactly DIG = floor(W/3)+1 rising edges after the edge that samples an accepted `start`, and it is low in every cycle of the run before that.
- R3: `done` is high for exactly one cycle per run.
- R4: The edge that accepts `start` clears `z_out` to 0. While the unit is idle and `start` is low, `z_out` holds its value, even if x, y and p change.
- R5: A `start` pulse that arrives while a run is in progress is ignored. The run in progress finishes on its normal schedule with its own result.
- R6: During a run, the accumulator is always in the range [0, p−1].
- R7: y is scanned as overlapping 4-bit windows over {zero padding, y, 0}. The padding brings the length above y up to a multiple of three: 3 zeros if W mod 3 = 0, 2 if W mod 3 = 1, 1 if W mod 3 = 2. The window is read from the top, and each step moves it down by three bits. A window b3 b2 b1 b0 has the digit −4·b3 + 2·b2 + b1 + b0. For example, 0111 gives +4, 1000 gives −4, and 1111 gives 0. A negative digit selects modular subtraction of |digit|·x mod p.
- R8: After a synchronous active-low reset, `z_out` is 0 and `done` is 0.
- R9: x = 0 or y = 0 yields 0.
- R10: A `start` given in the cycle where `done` is high is accepted. It begins a new run with the same timing as a run started from a long idle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a multiplication |
| x_in | input | W | Multiplicand, below p |
| y_in | input | W | Multiplier, below p |
| p_in | input | W | Odd modulus |
| z_out | output | W | Accumulator and final result |
| done | output | 1 | One-cycle flag: the result is valid on z_out |

## Verification
The completion of one run and the acceptance of the next request can share a cycle. In that cycle `done` is high, the finished result is on `z_out`, and a new `start` is sampled by the same edge that ends the done pulse. The bench drives `start` in exactly the done cycle. It checks that the first result was visible in that cycle, that `z_out` is cleared on the following edge, and that the second run finishes after the full DIG cycles with its own correct result. A separate scenario pulses `start` mid-run with different operands and expects neither the timing nor the result to move.

// File: rtl/mod_mul_r8_pkg.sv
// Package: shared types for the radix-8 modular multiplier.
// Holds the controller state encoding and the decoded Booth digit.
package mod_mul_r8_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mm_state_t;

    // Decoded Booth digit: sign and magnitude 0..4.
    typedef struct packed {
        logic       neg;
        logic [2:0] mag;
    } booth_dig_t;

endpackage

// File: rtl/mm_mod_dbl.sv
// Module: modular doubler.
// Returns 2a mod p. Assumes a < p, which keeps the result below p
// after at most one subtraction. Internal width W+2 keeps 2a - p
// from wrapping.
module mm_mod_dbl #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] p,
    output logic [W-1:0] r
);
    localparam int XW = W + 2;

    logic [XW-1:0] twice;
    logic [XW-1:0] trial;

    // Form 2a and 2a - p, keep the trial when it is not negative.
    always_comb begin
        twice = {1'b0, a, 1'b0};
        trial = twice - {2'b00, p};
        r     = trial[XW-1] ? twice[W-1:0] : trial[W-1:0];
    end
endmodule

// File: rtl/mm_mod_addsub.sv
// Module: modular adder / subtractor.
// Returns (a + b) mod p when sub = 0 and (a - b) mod p when sub = 1.
// Assumes a < p and b < p. One adder forms a +/- b, a second applies
// the correction by p, and a multiplexer picks the in-range value.
module mm_mod_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] p,
    input  logic         sub,
    output logic [W-1:0] r
);
    localparam int XW = W + 2;

    logic [XW-1:0] ax, bx, px;
    logic [XW-1:0] first;
    logic [XW-1:0] second;

    // Raw sum or difference, then the p-corrected companion.
    always_comb begin
        ax     = {2'b00, a};
        bx     = {2'b00, b};
        px     = {2'b00, p};
        first  = sub ? (ax - bx) : (ax + bx);
        second = sub ? (first + px) : (first - px);
    end

    // Select: a negative difference needs +p; a sum needs -p unless that goes negative.
    always_comb begin
        if (sub) begin
            r = first[XW-1] ? second[W-1:0] : first[W-1:0];
        end else begin
            r = second[XW-1] ? first[W-1:0] : second[W-1:0];
        end
    end
endmodule

// File: rtl/mm_booth_r8_dec.sv
// Module: radix-8 Booth window decoder.
// Maps a 4-bit overlapping window b3 b2 b1 b0 to the digit
// -4*b3 + 2*b2 + b1 + b0, returned as sign and magnitude.
// A zero digit is always reported as non-negative.
module mm_booth_r8_dec
    import mod_mul_r8_pkg::*;
(
    input  logic [3:0] win,
    output booth_dig_t dig
);
    logic [2:0] pos;

    // Positive part 2*b2 + b1 + b0, then fold in the -4 weight of b3.
    always_comb begin
        pos = {1'b0, win[2], 1'b0} + {2'b00, win[1]} + {2'b00, win[0]};
        if (win[3]) begin
            dig.mag = 3'd4 - pos;
            dig.neg = (pos != 3'd4);
        end else begin
            dig.mag = pos;
            dig.neg = 1'b0;
        end
    end
endmodule

// File: rtl/mod_mul_r8.sv
// Module: radix-8 Booth interleaved modular multiplier (top).
// Computes z = x*y mod p over DIG = floor(W/3)+1 cycles after start.
// Assumes x < p, y < p, p odd and > 1; otherwise the result is undefined.
// The start edge latches p, y and the multiples x, 2x, 3x, 4x mod p.
// Each run cycle takes 8z mod p through three doublers and then adds
// or subtracts the multiple chosen by the current Booth digit.
module mod_mul_r8
    import mod_mul_r8_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic [W-1:0] p_in,
    output logic [W-1:0] z_out,
    output logic         done
);
    localparam int PADW = 3 - (W % 3);
    localparam int NB   = W + PADW;
    localparam int DIG  = NB / 3;
    localparam int EXTW = NB + 1;
    localparam int CW   = $clog2(DIG + 1);
    localparam int NDBL = 3;

    mm_state_t      state_q;
    logic           busy;
    logic [W-1:0]   p_q, x1_q, x2_q, x3_q, x4_q;
    logic [EXTW-1:0] ysh_q;
    logic [CW-1:0]  cnt_q;
    logic [W-1:0]   z_q;
    logic           done_q;

    logic [W-1:0]   pre_x2, pre_x3, pre_x4;
    logic [W-1:0]   chain [NDBL+1];
    booth_dig_t     dig;
    logic [W-1:0]   pp;
    logic [W-1:0]   z_nxt;

    assign busy  = (state_q == ST_RUN);
    assign z_out = z_q;
    assign done  = done_q;

    // Precompute the multiples of x straight from the inputs.
    mm_mod_dbl #(.W(W)) pre_dbl2_i (.a(x_in),   .p(p_in), .r(pre_x2));
    mm_mod_dbl #(.W(W)) pre_dbl4_i (.a(pre_x2), .p(p_in), .r(pre_x4));
    mm_mod_addsub #(.W(W)) pre_add3_i (
        .a(x_in), .b(pre_x2), .p(p_in), .sub(1'b0), .r(pre_x3)
    );

    // Scale by eight: three modular doublers in series.
    assign chain[0] = z_q;
    for (genvar g = 0; g < NDBL; g++) begin : g_x8
        mm_mod_dbl #(.W(W)) dbl_i (.a(chain[g]), .p(p_q), .r(chain[g+1]));
    end

    // Decode the top window of the shifted multiplier.
    mm_booth_r8_dec dec_i (.win(ysh_q[EXTW-1 -: 4]), .dig(dig));

    // Choose the multiple that matches the digit magnitude.
    always_comb begin
        unique case (dig.mag)
            3'd1:    pp = x1_q;
            3'd2:    pp = x2_q;
            3'd3:    pp = x3_q;
            3'd4:    pp = x4_q;
            default: pp = '0;
        endcase
    end

    mm_mod_addsub #(.W(W)) acc_i (
        .a(chain[NDBL]), .b(pp), .p(p_q), .sub(dig.neg), .r(z_nxt)
    );

    // Controller: two states, idle waits for start, run counts digits down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= CW'(DIG);
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CW'(1)) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Operand registers: loaded only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q  <= '0;
            x1_q <= '0;
            x2_q <= '0;
            x3_q <= '0;
            x4_q <= '0;
        end else if (!busy && start) begin
            p_q  <= p_in;
            x1_q <= x_in;
            x2_q <= pre_x2;
            x3_q <= pre_x3;
            x4_q <= pre_x4;
        end
    end

    // Multiplier window register: padded load, then shift up by three per digit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ysh_q <= '0;
        end else if (!busy && start) begin
            ysh_q <= EXTW'({y_in, 1'b0});
        end else if (busy) begin
            ysh_q <= {ysh_q[EXTW-4:0], 3'b000};
        end
    end

    // Accumulator: cleared on start, updated each run cycle, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q <= '0;
        end else if (!busy && start) begin
            z_q <= '0;
        end else if (busy) begin
            z_q <= z_nxt;
        end
    end
endmodule

// File: rtl/mod_mul_r8_chk.sv
// Module: property checker for mod_mul_r8, attached with bind below.
// Observes the ports plus the run state, digit counter and latched modulus.
module mod_mul_r8_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input logic         busy,
    input logic [$clog2(W/3+2)-1:0] cnt,
    input logic [W-1:0] z,
    input logic [W-1:0] p_lat
);
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_on_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt == 1) |=> done);

    assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt > 1) |=> (busy && cnt == $past(cnt) - 1));

    assert_clear_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && z == '0));

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(z));

    assert_acc_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (z < p_lat));
endmodule

bind mod_mul_r8 mod_mul_r8_chk #(.W(W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .done  (done),
    .busy  (busy),
    .cnt   (cnt_q),
    .z     (z_q),
    .p_lat (p_q)
);

// File: tb/mod_mul_r8_tb_top.sv
// Bench: directed scenarios for mod_mul_r8 at W = 16 (DIG = 6).
module mod_mul_r8_tb_top;
    localparam int W   = 16;
    localparam int DIG = W / 3 + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] x_in = '0, y_in = '0, p_in = '0;
    logic [W-1:0] z_out;
    logic         done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit ended = 1'b0;
    logic [31:0] lcg = 32'h1234_5678;

    mod_mul_r8 #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_in(x_in), .y_in(y_in), .p_in(p_in),
        .z_out(z_out), .done(done)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !ended) begin
            ended = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [W-1:0] ref_mm(input logic [W-1:0] a, b, m);
        longint unsigned prod;
        prod = longint'(a) * longint'(b);
        return W'(prod % longint'(m));
    endfunction

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic next_rand(output logic [31:0] v);
        lcg = lcg * 32'd1103515245 + 32'd12345;
        v = lcg;
    endtask

    // Drive one start from a negedge and follow the run to done.
    // poke: pulse start mid-run with other operands. chain: leave start high
    // in the done cycle for a back-to-back run (caller sets the operands).
    task automatic run_one(input logic [W-1:0] a, b, m, input string req,
                           input bit poke, input bit chain,
                           input logic [W-1:0] na, nb, nm);
        logic [W-1:0] exp;
        int early;
        exp = ref_mm(a, b, m);
        x_in = a; y_in = b; p_in = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R4", "z cleared after start", z_out, 0);
        check("R2", "done low after start edge", done, 0);
        early = 0;
        for (int k = 1; k <= DIG; k++) begin
            @(negedge clk);
            if (poke && k == 2) begin
                x_in = m - 1; y_in = m - 2; start = 1'b1;
            end else if (poke && k == 3) begin
                start = 1'b0;
            end
            if (k < DIG && done) early++;
        end
        check("R2", "done before last digit", early, 0);
        check("R2", "done on last digit", done, 1);
        check(req, "result", z_out, exp);
        if (chain) begin
            x_in = na; y_in = nb; p_in = nm; start = 1'b1;
        end else begin
            @(negedge clk);
            check("R3", "done one cycle", done, 0);
            check("R4", "z held after done", z_out, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8", "z after reset", z_out, 0);
        check("R8", "done after reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_examples();
        run_one(16'd20, 16'd28, 16'd29, "R1", 0, 0, '0, '0, '0);
        check("R1", "small example", z_out, 9);
        run_one(16'd12548, 16'd12540, 16'd12553, "R1", 0, 0, '0, '0, '0);
        check("R1", "wide example", z_out, 65);
    endtask

    task automatic t_zeros();
        run_one(16'd0, 16'd1234, 16'd40961, "R9", 0, 0, '0, '0, '0);
        run_one(16'd777, 16'd0, 16'd40961, "R9", 0, 0, '0, '0, '0);
    endtask

    task automatic t_windows();
        logic [W-1:0] pats [8] = '{16'h7777, 16'h8888, 16'hF0F0, 16'h5A5A,
                                   16'hA5A5, 16'hCCCC, 16'h3333, 16'h1249};
        for (int i = 0; i < 8; i++) begin
            run_one(16'd54321, pats[i], 16'd65521, "R7", 0, 0, '0, '0, '0);
        end
        run_one(16'd65520, 16'd65520, 16'd65521, "R7", 0, 0, '0, '0, '0);
    endtask

    task automatic t_random();
        logic [31:0] r;
        logic [W-1:0] m, a, b;
        for (int i = 0; i < 40; i++) begin
            next_rand(r); m = r[W+7:8] | 16'h0001;
            if (m < 3) m = 16'd3;
            next_rand(r); a = W'(r[W+7:8] % m);
            next_rand(r); b = W'(r[W+7:8] % m);
            run_one(a, b, m, "R1", 0, 0, '0, '0, '0);
        end
    endtask

    task automatic t_ignore();
        run_one(16'd30000, 16'd29999, 16'd30011, "R5", 1, 0, '0, '0, '0);
    endtask

    task automatic t_hold();
        logic [W-1:0] exp;
        exp = ref_mm(16'd1111, 16'd2222, 16'd3001);
        run_one(16'd1111, 16'd2222, 16'd3001, "R1", 0, 0, '0, '0, '0);
        for (int k = 0; k < 4; k++) begin
            x_in = W'(k * 97); y_in = W'(k * 31); p_in = W'(k * 7 + 5);
            @(negedge clk);
        end
        check("R4", "z held while idle", z_out, exp);
    endtask

    task automatic t_back_to_back();
        run_one(16'd4000, 16'd5000, 16'd6007, "R10", 0, 1,
                16'd6000, 16'd123, 16'd6007);
        run_one(16'd6000, 16'd123, 16'd6007, "R10", 0, 0, '0, '0, '0);
    endtask

    initial begin
        t_reset();
        t_examples();
        t_zeros();
        t_windows();
        t_ignore();
        t_hold();
        t_back_to_back();
        t_random();
        ended = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule